// File: doc/BRIEF.md
# Chained Receive Descriptor Engine

This block moves incoming frames into host memory by following a linked list of receive descriptors. The host and the engine share a word-addressed memory. Each descriptor there is four 32-bit words: a status word, a size/control word, a buffer address and a link address. The host gives a descriptor to the engine by setting the top status bit. The engine fetches the descriptor and packs the bytes of the next frame into its buffer. At the end of the frame it writes the status word back with that bit cleared, the stored length and an error flag.

If the status bit shows that the host still holds the descriptor, the engine goes quiet. It drops any traffic until the host strobes a poll demand, which makes the engine read the status word again. The starting descriptor comes from a pointer that can be loaded while the engine is stopped. A level run enable starts and stops the engine at descriptor boundaries.

All pointers inside descriptors are word addresses, held in the low `ADDR_W` bits of their words. The memory port reads with one cycle of latency and accepts one access per cycle.

Top module: `rx_chain_engine`

## Requirements
- R1: After reset the engine issues no memory access while `run_en` is low. `ptr_load` sets the current descriptor pointer to `ptr_value` only while the engine is stopped, and is ignored while it runs.
- R2: When it runs, the engine reads the status word at the current pointer. If bit 31 is 0 it suspends with no memory traffic until `poll_kick` is strobed, which rereads that status word.
- R3: For an owned descriptor (status bit 31 = 1) the engine reads words 1 to 3. If bit 24 of word 1 (the chain flag, value 0x4 in control bits 31:22) is set, the next descriptor is the address in word 3; otherwise it is the current pointer plus 4.
- R4: Frame byte n is stored at word address (word 2) + n/4, in bits 8*(n%4)+7 : 8*(n%4) (little-endian). Unused lanes of a final partial word are written as zero.
- R5: At frame end the engine writes the status word with bit 31 = 0, bits 29:16 = number of stored bytes, bit 15 = error summary, and all other bits 0. It then moves to the next descriptor.
- R6: Bytes beyond the buffer size in bits 10:0 of word 1 are not written to memory. The length then equals that size and bit 15 is set. A size of 0 stores nothing.
- R7: A frame whose last byte carries `in_err` still closes its descriptor, with the length recorded and bit 15 set.
- R8: A frame opens only on a byte with `in_sof` while a descriptor is fetched and ready. Bytes that arrive while the engine is suspended, fetching or stopped, or that are not preceded by an accepted start byte, change no memory word.
- R9: If `run_en` falls during a frame, the frame still completes and closes. The engine then fetches nothing more. When `run_en` is raised again without a pointer load, it resumes at the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_load | input | 1 | Load the descriptor pointer (honoured while stopped) |
| ptr_value | input | ADDR_W | Word address of the first descriptor |
| run_en | input | 1 | Start (1) / stop (0) control |
| poll_kick | input | 1 | Poll-demand strobe: recheck ownership when suspended |
| in_valid | input | 1 | Frame byte valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame error flag, taken with the last byte |
| in_byte | input | 8 | Frame data byte |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bench builds the engine with the default `ADDR_W` of 10 and backs it with a full 1024-word memory. This leaves room to place descriptors eight words apart, so that only the link word can connect them. Buffers sit in a separate region that is pre-filled with a sentinel, so any discarded byte that reached memory would show. The table covers full, partial, overflowing, erroneous and zero-size buffers. The last link wraps to the first, now host-owned, descriptor, which drives the suspend and poll path. The directed tests after the table cover sequential (unchained) advance, headerless bytes, the pointer load being ignored while running, and a stop during a frame.

// File: rtl/rx_chain_engine.sv
module rx_chain_engine #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_value,
  input  logic              run_en,
  input  logic              poll_kick,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic [7:0]        in_byte,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);

  localparam int SZ_W      = 11;
  localparam int OWN_BIT   = 31;
  localparam int CHAIN_BIT = 24;
  localparam logic [ADDR_W-1:0] DESC_STRIDE = ADDR_W'(4);

  typedef enum logic [3:0] {
    S_IDLE, S_RSTAT, S_WSTAT, S_SUSP, S_F1, S_F2, S_F3, S_F4,
    S_READY, S_RECV, S_CLOSE
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] cur_q, buf_q, link_q;
  logic [SZ_W-1:0]   size_q, cnt_q;
  logic              chain_q, ovf_q, err_q;
  logic [31:0]       word_q;

  logic              unused_rdata;
  assign unused_rdata = ^mem_rdata;

  logic              take, first, fits, store, pend, flush;
  logic [SZ_W-1:0]   cnt;
  logic [1:0]        lane;
  logic [31:0]       wq, merged;
  logic [ADDR_W-1:0] next_ptr;

  assign take     = in_valid && ((st == S_READY && in_sof) || st == S_RECV);
  assign first    = (st == S_READY);
  assign cnt      = first ? '0 : cnt_q;
  assign fits     = cnt < size_q;
  assign store    = take && fits;
  assign lane     = cnt[1:0];
  assign pend     = lane != 2'd0;
  assign wq       = first ? '0 : word_q;
  assign merged   = wq | (32'(in_byte) << {lane, 3'b000});
  assign flush    = take && ((store && (lane == 2'd3 || in_eof)) || (in_eof && !store && pend));
  assign next_ptr = chain_q ? link_q : cur_q + DESC_STRIDE;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    case (st)
      S_RSTAT: mem_req = 1'b1;
      S_F1: begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(1); end
      S_F2: begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(2); end
      S_F3: begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(3); end
      S_READY, S_RECV: begin
        mem_req   = flush;
        mem_we    = flush;
        mem_addr  = buf_q + ADDR_W'(cnt[SZ_W-1:2]);
        mem_wdata = store ? merged : wq;
      end
      S_CLOSE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {2'b00, 3'b000, cnt_q, err_q, 15'b0};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur_q   <= '0;
      buf_q   <= '0;
      link_q  <= '0;
      size_q  <= '0;
      cnt_q   <= '0;
      chain_q <= 1'b0;
      ovf_q   <= 1'b0;
      err_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ptr_load) cur_q <= ptr_value;
          if (run_en) st <= S_RSTAT;
        end
        S_RSTAT: st <= S_WSTAT;
        S_WSTAT: st <= mem_rdata[OWN_BIT] ? S_F1 : S_SUSP;
        S_SUSP: begin
          if (!run_en) st <= S_IDLE;
          else if (poll_kick) st <= S_RSTAT;
        end
        S_F1: st <= S_F2;
        S_F2: begin
          size_q  <= mem_rdata[SZ_W-1:0];
          chain_q <= mem_rdata[CHAIN_BIT];
          st      <= S_F3;
        end
        S_F3: begin
          buf_q <= mem_rdata[ADDR_W-1:0];
          st    <= S_F4;
        end
        S_F4: begin
          link_q <= mem_rdata[ADDR_W-1:0];
          st     <= S_READY;
        end
        S_READY, S_RECV: begin
          if (take) begin
            cnt_q  <= cnt + SZ_W'(store);
            word_q <= flush ? '0 : (store ? merged : wq);
            ovf_q  <= (first ? 1'b0 : ovf_q) | !fits;
            if (in_eof) begin
              err_q <= (first ? 1'b0 : ovf_q) | !fits | in_err;
              st    <= S_CLOSE;
            end else begin
              st <= S_RECV;
            end
          end else if (st == S_READY && !run_en) begin
            st <= S_IDLE;
          end
        end
        S_CLOSE: begin
          cur_q <= next_ptr;
          st    <= run_en ? S_RSTAT : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !run_en) |=> !mem_req);

  p_suspend_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUSP) |-> !mem_req);

  p_fetch_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F1) |-> $past(mem_rdata[OWN_BIT]));

  p_buf_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && st != S_CLOSE) |-> ((mem_addr - buf_q) <= ADDR_W'(size_q[SZ_W-1:2])));

  p_release_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLOSE) |-> (mem_we && !mem_wdata[OWN_BIT]));

  p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLOSE) |-> (mem_wdata[29:16] <= 14'(size_q)));

  p_ovf_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLOSE && ovf_q) |-> mem_wdata[15]);

  p_stop_after_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLOSE && !run_en) |=> (st == S_IDLE));

endmodule

// File: tb/rx_chain_engine_tb_top.sv
module rx_chain_engine_tb_top;
  localparam int AW = 10;
  localparam int NV = 6;
  // {frame_len, buf_size, err_in, exp_len, exp_err}
  localparam logic [39:0] VEC [NV] = '{
    {8'd8,  8'd64, 8'd0, 8'd8, 8'd1 - 8'd1},
    {8'd5,  8'd64, 8'd0, 8'd5, 8'd0},
    {8'd10, 8'd6,  8'd0, 8'd6, 8'd1},
    {8'd3,  8'd64, 8'd1, 8'd3, 8'd1},
    {8'd1,  8'd64, 8'd0, 8'd1, 8'd0},
    {8'd7,  8'd0,  8'd0, 8'd0, 8'd1}
  };
  localparam logic [31:0] SENT = 32'h25A5A5A5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ptr_load = 1'b0, run_en = 1'b0, poll_kick = 1'b0;
  logic [AW-1:0] ptr_value = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0] in_byte = '0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [1 << AW];
  int rd_cnt = 0, wr_cnt = 0, checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  rx_chain_engine #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_value(ptr_value),
    .run_en(run_en), .poll_kick(poll_kick), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_err(in_err), .in_byte(in_byte), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      if (mem_we) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
      else begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [7:0] seed, input logic err,
                      input logic with_sof, input logic stop_mid);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = with_sof && (k == 0);
      in_eof   = (k == n - 1);
      in_err   = err && (k == n - 1);
      in_byte  = seed + 8'(k);
      if (stop_mid && k == 1) run_en = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
  endtask

  function automatic logic [31:0] ew(input logic [7:0] seed, input int n, input int w);
    logic [31:0] r = '0;
    for (int l = 0; l < 4; l++)
      if (4 * w + l < n) r[8*l +: 8] = seed + 8'(4 * w + l);
    return r;
  endfunction

  function automatic logic [31:0] stw(input int len, input logic e);
    return (32'(len) << 16) | (32'(e) << 15);
  endfunction

  task automatic desc(input int a, input int size, input logic chain, input int bufa, input int link);
    mem[a]   = 32'h8000_0000;
    mem[a+1] = (32'(chain) << 24) | 32'(size);
    mem[a+2] = 32'(bufa);
    mem[a+3] = 32'(link);
  endtask

  task automatic chk_buf(input string req, input int bufa, input logic [7:0] seed, input int n);
    int nw = (n + 3) / 4;
    for (int w = 0; w < nw; w++) chk(req, mem[bufa + w], ew(seed, n, w));
    chk(req, mem[bufa + nw], SENT);
  endtask

  initial begin
    int r0, w0;
    for (int a = 0; a < (1 << AW); a++) mem[a] = SENT;
    mem[16'h90] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(6);
    // R1: quiet after reset while stopped
    chk("R1 reset mem_req", 32'(mem_req), 32'h0);
    chk("R1 reset access count", 32'(rd_cnt + wr_cnt), 32'h0);

    for (int i = 0; i < NV; i++)
      desc(16'h40 + 8 * i, int'(VEC[i][31:24]), 1'b1, 16'h100 + 16'h20 * i,
           (i == NV - 1) ? 16'h40 : 16'h48 + 8 * i);
    ptr_value = 10'h40; ptr_load = 1'b1;
    @(negedge clk); ptr_load = 1'b0; run_en = 1'b1;
    idle(20);

    // Table: R4 packing, R5 status, R6 overflow / zero size, R7 error, R3 chain links
    for (int i = 0; i < NV; i++) begin
      send(int'(VEC[i][39:32]), 8'(16 * i + 1), VEC[i][16], 1'b1, 1'b0);
      idle(20);
      chk("R5 status word", mem[16'h40 + 8 * i], stw(int'(VEC[i][15:8]), VEC[i][0]));
      chk_buf("R4 R6 buffer", 16'h100 + 16'h20 * i, 8'(16 * i + 1), int'(VEC[i][15:8]));
    end

    // R2: wrapped to host-owned first descriptor, suspended and quiet; frame dropped (R8)
    r0 = rd_cnt; w0 = wr_cnt;
    send(4, 8'h77, 1'b0, 1'b1, 1'b0);
    idle(20);
    chk("R2 no reads while suspended", 32'(rd_cnt), 32'(r0));
    chk("R8 suspended frame dropped", 32'(wr_cnt), 32'(w0));

    // R2 poll re-check, R3 sequential advance without chain flag
    desc(16'h40, 64, 1'b0, 16'h200, 16'h3F0);
    desc(16'h44, 64, 1'b1, 16'h240, 16'h90);
    @(negedge clk); poll_kick = 1'b1;
    @(negedge clk); poll_kick = 1'b0;
    idle(20);
    send(6, 8'hC0, 1'b0, 1'b1, 1'b0);
    idle(20);
    chk("R2 poll resumes", mem[16'h40], stw(6, 1'b0));
    chk_buf("R4 poll frame", 16'h200, 8'hC0, 6);
    send(4, 8'hD0, 1'b0, 1'b1, 1'b0);
    idle(20);
    chk("R3 sequential next", mem[16'h44], stw(4, 1'b0));
    chk_buf("R3 sequential buf", 16'h240, 8'hD0, 4);

    // R1: pointer load while stopped
    run_en = 1'b0;
    idle(5);
    desc(16'hA0, 64, 1'b1, 16'h280, 16'hB0);
    desc(16'hB0, 64, 1'b1, 16'h2C0, 16'h90);
    ptr_value = 10'hA0; ptr_load = 1'b1;
    @(negedge clk); ptr_load = 1'b0; run_en = 1'b1;
    idle(20);
    // R1: load ignored while running
    ptr_value = 10'h90; ptr_load = 1'b1;
    @(negedge clk); ptr_load = 1'b0;
    idle(5);
    // R8: bytes without a start byte are dropped
    w0 = wr_cnt;
    send(5, 8'h55, 1'b0, 1'b0, 1'b0);
    idle(10);
    chk("R8 headerless bytes dropped", 32'(wr_cnt), 32'(w0));
    send(4, 8'hE0, 1'b0, 1'b1, 1'b0);
    idle(20);
    chk("R1 load used while stopped, ignored while running", mem[16'hA0], stw(4, 1'b0));
    chk_buf("R4 loaded desc buf", 16'h280, 8'hE0, 4);

    // R9: stop mid-frame, frame closes, nothing fetched after
    r0 = rd_cnt;
    send(4, 8'hF0, 1'b1, 1'b1, 1'b1);
    idle(20);
    chk("R9 frame closes after stop", mem[16'hB0], stw(4, 1'b1));
    chk("R9 no fetch after stop", 32'(rd_cnt), 32'(r0));
    desc(16'h90, 64, 1'b1, 16'h300, 16'h90);
    @(negedge clk); run_en = 1'b1;
    idle(20);
    send(2, 8'h33, 1'b0, 1'b1, 1'b0);
    idle(20);
    chk("R9 resumes at next descriptor", mem[16'h90], stw(2, 1'b0));
    chk_buf("R9 resume buffer", 16'h300, 8'h33, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule